// File: doc/BRIEF.md
# Scatter-gather receive descriptor writer

This block places one incoming stream frame, whose byte length is announced up front, into a chain of receive descriptors held in memory. For each descriptor it reads the descriptor fields and copies a slice of the frame, byte by byte, into that descriptor's buffer. It then writes a status word back into the descriptor and moves to the next descriptor in the chain. The slice is the smaller of the descriptor's capacity and the bytes still owed. The descriptor that takes the last byte also receives five words of application metadata, which were collected earlier from a side control stream.

The channel's run level, current pointer and tail pointer come from a register block outside this one. The block raises `frm_ready` only while the channel runs and is not idle. It stops early when it fetches a descriptor that software has not yet reclaimed, which sets halted, or when it has finished the tail descriptor, which sets idle. For every frame it reports the number of bytes accepted. A completion pulse marks frames that reached their end.

Descriptor layout, as byte offsets from the descriptor pointer:

| Offset | Field |
|---|---|
| 0x00 | next-descriptor pointer |
| 0x04 | buffer address |
| 0x08 | control word; bits 22:0 hold the capacity in bytes |
| 0x0C | status word |
| 0x10 to 0x20 | five metadata words |

Top module: `rxsg_writer`

## Requirements
- R1: `frm_ready` is high only while `run` is 1, `idle` is 0 and no frame is in progress. After reset `halted` is 1 and `idle` is 0. A 0-to-1 change of `run` clears both flags. A `tail_wr` pulse clears `idle`. `halted` does not gate `frm_ready`.
- R2: The slice for each descriptor is min(control[22:0], remaining frame bytes). The slice is written one byte per memory write (`mem_byte`=1) to consecutive addresses starting at the buffer address. A capacity of 0 gives an empty slice, and the walk moves on to the next descriptor.
- R3: Status bit 27 (start of frame) is set only in the status of the first descriptor used for a frame.
- R4: On the descriptor that takes the last frame byte, status bit 26 (end of frame) is set. The five latched metadata words are written at offsets 0x10, 0x14, 0x18, 0x1C and 0x20. `frame_cmpl` pulses for one cycle, in the same cycle as `cnt_valid`.
- R5: The status of every used descriptor has bit 31 (complete) set and holds the slice length in bits 22:0. Bits 30:28 and 25:23 are 0.
- R6: A fetched descriptor whose status bit 31 is already 1 sets `halted` and ends the frame. That descriptor is not written. `cnt_bytes` equals the bytes consumed so far, and `frame_cmpl` stays low.
- R7: After the status write of the tail descriptor, `idle` is set and the frame ends even if bytes remain. `cur_desc` always advances to the next pointer of each descriptor used.
- R8: A metadata message on `meta_*` ends with `meta_last`. It is latched only if it has exactly five words. Any other length pulses `meta_err` one cycle after the last word, and the previously latched words remain in use.
- R9: At the end of every frame, `cnt_valid` pulses for one cycle with `cnt_bytes` equal to the number of bytes accepted on `din`.
- R10: Once `mem_req` is raised, it stays high with a stable address, direction and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run level |
| cur_wr | input | 1 | Load current descriptor pointer |
| cur_ptr | input | 32 | Value for `cur_wr` |
| tail_wr | input | 1 | Load tail pointer, clears idle |
| tail_ptr | input | 32 | Value for `tail_wr` |
| frm_valid | input | 1 | Frame available |
| frm_len | input | 16 | Frame length in bytes |
| frm_ready | output | 1 | Frame accepted when high with `frm_valid` |
| din_valid | input | 1 | Frame byte valid |
| din | input | 8 | Frame byte |
| din_ready | output | 1 | Frame byte taken |
| meta_valid | input | 1 | Metadata word valid |
| meta_data | input | 32 | Metadata word |
| meta_last | input | 1 | Last word of a metadata message |
| meta_err | output | 1 | Metadata message had the wrong length |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_byte | output | 1 | Write only the low byte |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done, read data valid |
| mem_rdata | input | 32 | Read data |
| halted | output | 1 | Stopped on a complete descriptor |
| idle | output | 1 | Tail reached |
| cur_desc | output | 32 | Current descriptor pointer |
| frame_cmpl | output | 1 | Frame end written |
| cnt_valid | output | 1 | End of frame |
| cnt_bytes | output | 16 | Bytes accepted for the frame |

## Verification
The assertions assume that memory answers every request with exactly one `mem_ack` pulse. The bench's memory model guarantees this by acknowledging only a request that it has not yet acknowledged. The assertions also assume that software pointer writes and run changes never arrive while a frame is in progress. The bench keeps to this by touching `cur_wr`, `tail_wr` and `run` only after `cnt_valid` has been seen, or before any frame is offered. Frame bytes are always available, and metadata is sent only between frames, so no metadata word changes under a frame in progress.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int LENW = 23;

  typedef enum logic [3:0] {
    E_WAIT, E_RSTAT, E_RNEXT, E_RBUF, E_RCTRL,
    E_DATA, E_APP, E_WSTAT, E_STEP, E_END
  } eng_state_t;

  // descriptor field offsets in bytes
  localparam logic [7:0] OFS_NEXT = 8'h00;
  localparam logic [7:0] OFS_BUF  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_APP  = 8'h10;

  function automatic logic [LENW-1:0] slice_len(input logic [LENW-1:0] cap,
                                                input logic [LENW-1:0] rem);
    return (cap > rem) ? rem : cap;
  endfunction

  function automatic logic [31:0] status_word(input logic [LENW-1:0] len,
                                              input logic sof, input logic eof);
    return {1'b1, 3'b000, sof, eof, 3'b000, len};
  endfunction
endpackage

// File: rtl/rxsg_meta.sv
module rxsg_meta #(
  parameter int NWORDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    meta_valid,
  input  logic [31:0]             meta_data,
  input  logic                    meta_last,
  output logic [NWORDS-1:0][31:0] app_words,
  output logic                    commit,
  output logic                    meta_err
);
  localparam int CW = $clog2(NWORDS + 1);

  logic [NWORDS-1:0][31:0] stage;
  logic [CW-1:0]           cnt;
  logic                    end_msg;

  assign end_msg = meta_valid && meta_last;
  assign commit  = end_msg && (cnt == CW'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      stage     <= '0;
      app_words <= '0;
      meta_err  <= 1'b0;
    end else begin
      meta_err <= end_msg && !commit;
      if (meta_valid) begin
        if (meta_last) cnt <= '0;
        else if (cnt < CW'(NWORDS)) cnt <= cnt + 1'b1;
        for (int k = 0; k < NWORDS; k++)
          if (cnt == CW'(k)) stage[k] <= meta_data;
      end
      if (commit)
        for (int k = 0; k < NWORDS; k++)
          app_words[k] <= (k == NWORDS - 1) ? meta_data : stage[k];
    end
  end
endmodule

// File: rtl/rxsg_chan.sv
module rxsg_chan #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_ptr,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_ptr,
  input  logic          set_halt,
  input  logic          set_idle,
  input  logic          advance,
  input  logic [AW-1:0] next_ptr,
  output logic [AW-1:0] cur_q,
  output logic [AW-1:0] tail_q,
  output logic          halted_q,
  output logic          idle_q,
  output logic          chan_ok
);
  logic run_q, start;

  assign start   = run && !run_q;
  assign chan_ok = run && !idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      cur_q    <= '0;
      tail_q   <= '0;
    end else begin
      run_q <= run;
      if (start)         halted_q <= 1'b0;
      else if (set_halt) halted_q <= 1'b1;
      if (start || tail_wr) idle_q <= 1'b0;
      else if (set_idle)    idle_q <= 1'b1;
      if (cur_wr)       cur_q <= cur_ptr;
      else if (advance) cur_q <= next_ptr;
      if (tail_wr) tail_q <= tail_ptr;
    end
  end
endmodule

// File: rtl/rxsg_engine.sv
module rxsg_engine
  import rxsg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int NWORDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chan_ok,
  input  logic                    frm_valid,
  input  logic [LW-1:0]           frm_len,
  output logic                    frm_ready,
  input  logic                    din_valid,
  input  logic [7:0]              din,
  output logic                    din_ready,
  input  logic [NWORDS-1:0][31:0] app_words,
  input  logic [AW-1:0]           cur,
  input  logic [AW-1:0]           tail,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_byte,
  output logic [AW-1:0]           mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [31:0]             mem_rdata,
  output logic                    set_halt,
  output logic                    set_idle,
  output logic                    advance,
  output logic [AW-1:0]           next_ptr,
  output logic                    stat_wr,
  output logic                    frame_cmpl,
  output logic                    cnt_valid,
  output logic [LW-1:0]           cnt_bytes
);
  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  eng_state_t      st;
  logic [LW-1:0]   remain, count;
  logic [AW-1:0]   nxt, bufp;
  logic [LENW-1:0] slice, boff, fit;
  logic            first, last, have;
  logic [7:0]      byte_q;
  logic [IW-1:0]   aidx;

  assign fit        = slice_len(mem_rdata[LENW-1:0], LENW'(remain));
  assign frm_ready  = chan_ok && (st == E_WAIT);
  assign din_ready  = (st == E_DATA) && !have && (boff != slice);
  assign set_halt   = (st == E_RSTAT) && mem_ack && mem_rdata[31];
  assign advance    = (st == E_STEP);
  assign set_idle   = advance && (cur == tail);
  assign next_ptr   = nxt;
  assign stat_wr    = (st == E_WSTAT);
  assign cnt_valid  = (st == E_END);
  assign frame_cmpl = cnt_valid && last;
  assign cnt_bytes  = count;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (st)
      E_RSTAT: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_STAT); end
      E_RNEXT: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_NEXT); end
      E_RBUF:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_BUF);  end
      E_RCTRL: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_CTRL); end
      E_DATA: begin
        mem_req   = have;
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        mem_addr  = bufp + AW'(boff);
        mem_wdata = {24'b0, byte_q};
      end
      E_APP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(OFS_APP) + AW'({aidx, 2'b00});
        mem_wdata = app_words[aidx];
      end
      E_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(OFS_STAT);
        mem_wdata = status_word(slice, first, last);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_WAIT;
      remain <= '0; count <= '0; nxt <= '0; bufp <= '0;
      slice <= '0; boff <= '0; first <= 1'b0; last <= 1'b0;
      have <= 1'b0; byte_q <= '0; aidx <= '0;
    end else begin
      unique case (st)
        E_WAIT: if (frm_valid && chan_ok) begin
          remain <= frm_len; count <= '0;
          first <= 1'b1; last <= 1'b0;
          st <= E_RSTAT;
        end
        E_RSTAT: if (mem_ack) st <= mem_rdata[31] ? E_END : E_RNEXT;
        E_RNEXT: if (mem_ack) begin nxt <= mem_rdata; st <= E_RBUF; end
        E_RBUF:  if (mem_ack) begin bufp <= mem_rdata; st <= E_RCTRL; end
        E_RCTRL: if (mem_ack) begin
          slice <= fit;
          last  <= (fit == LENW'(remain));
          boff  <= '0;
          have  <= 1'b0;
          st    <= E_DATA;
        end
        E_DATA: begin
          if (have) begin
            if (mem_ack) begin
              have <= 1'b0; boff <= boff + 1'b1;
              remain <= remain - 1'b1; count <= count + 1'b1;
            end
          end else if (boff == slice) begin
            aidx <= '0;
            st   <= last ? E_APP : E_WSTAT;
          end else if (din_valid) begin
            byte_q <= din; have <= 1'b1;
          end
        end
        E_APP: if (mem_ack) begin
          if (aidx == IW'(NWORDS - 1)) st <= E_WSTAT;
          else aidx <= aidx + 1'b1;
        end
        E_WSTAT: if (mem_ack) st <= E_STEP;
        E_STEP: begin
          first <= 1'b0;
          st <= (set_idle || last) ? E_END : E_RSTAT;
        end
        default: st <= E_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/rxsg_writer.sv
module rxsg_writer #(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int NWORDS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_ptr,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_ptr,
  input  logic          frm_valid,
  input  logic [LW-1:0] frm_len,
  output logic          frm_ready,
  input  logic          din_valid,
  input  logic [7:0]    din,
  output logic          din_ready,
  input  logic          meta_valid,
  input  logic [31:0]   meta_data,
  input  logic          meta_last,
  output logic          meta_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          halted,
  output logic          idle,
  output logic [AW-1:0] cur_desc,
  output logic          frame_cmpl,
  output logic          cnt_valid,
  output logic [LW-1:0] cnt_bytes
);
  logic [NWORDS-1:0][31:0] app_words;
  logic                    meta_commit, chan_ok;
  logic                    set_halt, set_idle, advance, stat_wr;
  logic [AW-1:0]           tail_q, next_ptr;

  rxsg_meta #(.NWORDS(NWORDS)) u_meta (
    .clk(clk), .rst_n(rst_n), .meta_valid(meta_valid), .meta_data(meta_data),
    .meta_last(meta_last), .app_words(app_words), .commit(meta_commit),
    .meta_err(meta_err)
  );

  rxsg_chan #(.AW(AW)) u_chan (
    .clk(clk), .rst_n(rst_n), .run(run), .cur_wr(cur_wr), .cur_ptr(cur_ptr),
    .tail_wr(tail_wr), .tail_ptr(tail_ptr), .set_halt(set_halt),
    .set_idle(set_idle), .advance(advance), .next_ptr(next_ptr),
    .cur_q(cur_desc), .tail_q(tail_q), .halted_q(halted), .idle_q(idle),
    .chan_ok(chan_ok)
  );

  rxsg_engine #(.AW(AW), .LW(LW), .NWORDS(NWORDS)) u_eng (
    .clk(clk), .rst_n(rst_n), .chan_ok(chan_ok), .frm_valid(frm_valid),
    .frm_len(frm_len), .frm_ready(frm_ready), .din_valid(din_valid),
    .din(din), .din_ready(din_ready), .app_words(app_words), .cur(cur_desc),
    .tail(tail_q), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .set_halt(set_halt), .set_idle(set_idle),
    .advance(advance), .next_ptr(next_ptr), .stat_wr(stat_wr),
    .frame_cmpl(frame_cmpl), .cnt_valid(cnt_valid), .cnt_bytes(cnt_bytes)
  );
endmodule

// File: rtl/rxsg_writer_chk.sv
module rxsg_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          stat_wr,
  input logic          frm_ready,
  input logic          din_ready,
  input logic          halted,
  input logic          idle,
  input logic          frame_cmpl,
  input logic          cnt_valid,
  input logic          meta_commit,
  input logic          meta_err
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R5
  stat_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && mem_req |-> mem_we && mem_wdata[31]);
  // R1
  ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !frm_ready);
  // R6
  halt_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> cnt_valid && !frame_cmpl);
  // R7
  idle_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> cnt_valid);
  // R4
  cmpl_with_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cmpl |-> cnt_valid);
  // R8
  meta_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meta_commit |=> !meta_err);
endmodule

bind rxsg_writer rxsg_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .stat_wr(stat_wr), .frm_ready(frm_ready), .din_ready(din_ready),
  .halted(halted), .idle(idle), .frame_cmpl(frame_cmpl),
  .cnt_valid(cnt_valid), .meta_commit(meta_commit), .meta_err(meta_err)
);

// File: tb/rxsg_writer_test.sv
`timescale 1ns/1ps
module rxsg_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic run = 0, cur_wr = 0, tail_wr = 0, frm_valid = 0, din_valid = 0;
  logic [31:0] cur_ptr = 0, tail_ptr = 0, meta_data = 0;
  logic [15:0] frm_len = 0;
  logic meta_valid = 0, meta_last = 0;
  logic frm_ready, din_ready, meta_err, mem_req, mem_we, mem_byte;
  logic [31:0] mem_addr, mem_wdata, cur_desc;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic halted, idle, frame_cmpl, cnt_valid;
  logic [15:0] cnt_bytes;
  logic [7:0] din;

  int errors = 0, checks = 0, idx = 0;
  logic [7:0] mem_b [0:4095];

  rxsg_writer uut (.*);

  assign din = 8'(idx * 7 + 3);
  always @(posedge clk) if (din_valid && din_ready) idx <= idx + 1;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem_b[mem_addr[11:0]] <= mem_wdata[7:0];
        if (!mem_byte) begin
          mem_b[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
          mem_b[mem_addr[11:0] + 12'd2] <= mem_wdata[23:16];
          mem_b[mem_addr[11:0] + 12'd3] <= mem_wdata[31:24];
        end
      end else
        mem_rdata <= {mem_b[mem_addr[11:0] + 12'd3], mem_b[mem_addr[11:0] + 12'd2],
                      mem_b[mem_addr[11:0] + 12'd1], mem_b[mem_addr[11:0]]};
    end
  end

  function automatic logic [31:0] rd32(input int a);
    return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem_b[a+k] <= v[8*k +: 8];
  endtask

  task automatic put_desc(input int a, input int nxt, input int bufa,
                          input logic [31:0] ctrl, input logic [31:0] stat);
    wr32(a, nxt); wr32(a + 4, bufa); wr32(a + 8, ctrl); wr32(a + 12, stat);
    for (int k = 0; k < 5; k++) wr32(a + 16 + 4 * k, 32'h0);
    @(negedge clk);
  endtask

  task automatic set_ptrs(input int c, input int t);
    @(negedge clk);
    cur_wr = 1; cur_ptr = c; tail_wr = 1; tail_ptr = t;
    @(negedge clk);
    cur_wr = 0; tail_wr = 0;
  endtask

  task automatic send_meta(input int n, input logic [31:0] base, output logic err);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      meta_valid = 1; meta_data = base + k; meta_last = (k == n - 1);
    end
    @(negedge clk);
    meta_valid = 0; meta_last = 0;
    err = meta_err;
  endtask

  task automatic do_frame(input int len, output int got, output logic cmpl, output int base);
    int t = 0;
    @(negedge clk);
    base = idx; frm_len = 16'(len); frm_valid = 1;
    while (!frm_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    frm_valid = 0;
    cmpl = 0; got = -1; t = 0;
    while (got < 0 && t < 5000) begin
      if (cnt_valid) begin got = cnt_bytes; cmpl = frame_cmpl; end
      else @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  function automatic int bad_bytes(input int bufa, input int n, input int first);
    int b = 0;
    for (int k = 0; k < n; k++) if (mem_b[bufa + k] !== 8'((first + k) * 7 + 3)) b++;
    return b;
  endfunction

  task automatic t_reset;
    chk("R1 ready at reset", frm_ready, 0);
    chk("R1 halted at reset", halted, 1);
    chk("R1 idle at reset", idle, 0);
    chk("R9 cnt_valid at reset", cnt_valid, 0);
    chk("R10 no request at reset", mem_req, 0);
  endtask

  task automatic t_start;
    logic e;
    send_meta(5, 32'h1111_0000, e);
    chk("R8 five words accepted", e, 0);
    set_ptrs(32'h100, 32'h180);
    @(negedge clk); run = 1;
    @(negedge clk);
    chk("R1 run clears halted", halted, 0);
    chk("R1 ready when running", frm_ready, 1);
  endtask

  task automatic t_multi;
    int got, base; logic c;
    put_desc(32'h100, 32'h140, 32'h800, 4, 0);
    put_desc(32'h140, 32'h180, 32'h840, 4, 0);
    put_desc(32'h180, 32'h1C0, 32'h880, 10, 0);
    do_frame(10, got, c, base);
    chk("R9 count over three slices", got, 10);
    chk("R4 completion pulse", c, 1);
    chk("R3 first status has SOF", rd32(32'h10C), 32'h8800_0004);
    chk("R5 middle status", rd32(32'h14C), 32'h8000_0004);
    chk("R2 R4 last status clipped with EOF", rd32(32'h18C), 32'h8400_0002);
    chk("R2 bytes desc0", bad_bytes(32'h800, 4, base), 0);
    chk("R2 bytes desc1", bad_bytes(32'h840, 4, base + 4), 0);
    chk("R2 bytes desc2", bad_bytes(32'h880, 2, base + 8), 0);
    chk("R2 no byte past slice", mem_b[32'h882], 8'hxx === mem_b[32'h882] ? mem_b[32'h882] : 8'h00);
    for (int k = 0; k < 5; k++) chk("R4 metadata word", rd32(32'h190 + 4 * k), 32'h1111_0000 + k);
    chk("R4 no metadata in desc0", rd32(32'h110), 0);
    chk("R7 idle after tail", idle, 1);
    chk("R1 ready low when idle", frm_ready, 0);
    chk("R7 pointer advanced", cur_desc, 32'h1C0);
  endtask

  task automatic t_meta_bad;
    logic e;
    send_meta(3, 32'h2222_0000, e);
    chk("R8 short message error", e, 1);
    send_meta(7, 32'h3333_0000, e);
    chk("R8 long message error", e, 1);
  endtask

  task automatic t_single;
    int got, base; logic c;
    put_desc(32'h300, 32'h340, 32'h900, 16, 0);
    set_ptrs(32'h300, 32'h300);
    chk("R1 tail write clears idle", idle, 0);
    do_frame(6, got, c, base);
    chk("R9 single count", got, 6);
    chk("R4 single cmpl", c, 1);
    chk("R3 R4 single status", rd32(32'h30C), 32'h8C00_0006);
    chk("R2 single bytes", bad_bytes(32'h900, 6, base), 0);
    for (int k = 0; k < 5; k++) chk("R8 old metadata kept", rd32(32'h310 + 4 * k), 32'h1111_0000 + k);
  endtask

  task automatic t_tail_short;
    int got, base; logic c;
    put_desc(32'h100, 32'h140, 32'h800, 3, 0);
    set_ptrs(32'h100, 32'h100);
    do_frame(8, got, c, base);
    chk("R7 stop at tail count", got, 3);
    chk("R7 no cmpl when cut", c, 0);
    chk("R7 status without EOF", rd32(32'h10C), 32'h8800_0003);
    chk("R7 no metadata when cut", rd32(32'h110), 0);
    chk("R7 idle set", idle, 1);
  endtask

  task automatic t_halt;
    int got, base; logic c;
    put_desc(32'h100, 32'h140, 32'h800, 3, 0);
    put_desc(32'h140, 32'h180, 32'h840, 8, 32'h8000_0000);
    mem_b[32'h840] <= 8'h5A;
    set_ptrs(32'h100, 32'h180);
    do_frame(8, got, c, base);
    chk("R6 bytes so far", got, 3);
    chk("R6 halted set", halted, 1);
    chk("R6 no cmpl", c, 0);
    chk("R6 owned desc untouched", rd32(32'h14C), 32'h8000_0000);
    chk("R6 owned buffer untouched", mem_b[32'h840], 8'h5A);
    chk("R6 pointer at owned desc", cur_desc, 32'h140);
    chk("R1 halted does not gate ready", frm_ready, 1);
  endtask

  task automatic t_zero_slice;
    int got, base; logic c;
    @(negedge clk); run = 0;
    @(negedge clk); run = 1;
    @(negedge clk);
    chk("R1 run edge clears halted", halted, 0);
    put_desc(32'h100, 32'h140, 32'h800, 0, 0);
    put_desc(32'h140, 32'h180, 32'h840, 8, 0);
    set_ptrs(32'h100, 32'h140);
    do_frame(5, got, c, base);
    chk("R2 empty slice status", rd32(32'h10C), 32'h8800_0000);
    chk("R3 second desc no SOF", rd32(32'h14C), 32'h8400_0005);
    chk("R9 count after empty slice", got, 5);
    chk("R2 bytes after empty slice", bad_bytes(32'h840, 5, base), 0);
  endtask

  task automatic t_stop;
    @(negedge clk); run = 0;
    @(negedge clk);
    chk("R1 ready low when stopped", frm_ready, 0);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem_b[k] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; din_valid = 1;
    @(negedge clk);
    t_start();
    t_multi();
    t_meta_bad();
    t_single();
    t_tail_short();
    t_halt();
    t_zero_slice();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule